// File: doc/BRIEF.md
# Layered Liveness Supervisor with Fault Localisation

This block watches several monitored functions at once. Each function proves that it is alive by pulsing its kick line before its own countdown runs out. The block does not look at why a function stopped. It reacts only when the proof of liveness is missing, so a stalled program and a hung state machine look the same to it. A function can also strobe a short access-point code as it passes marked places in its flow. The block keeps the latest code for each function. When a timeout occurs, that code is captured, so the place where execution stopped can be read back.

Recovery works in layers. At the lowest layer, a timeout resets only the function that failed, using a fixed-length local reset pulse. After the pulse, that channel reloads its countdown and starts watching again. At the next layer, every timeout sets a sticky exception bit that the monitoring layer above can see. A cause field names the lowest-numbered channel that is pending, together with the access point captured for it. At the top layer, a channel that keeps timing out a set number of times in a row, with no successful kick in between, produces a one-cycle global reset request.

Top module: `multi_wdog`

## Requirements
- R1: After reset, `local_rst`, `exc_pending`, `exc_irq` and `glb_rst_req` are all 0. Every channel's timeout value and countdown hold `DEF_TIMEOUT`. An enabled channel that is never kicked starts its local reset at the (`DEF_TIMEOUT`+1)-th rising edge at which it is sampled enabled.
- R2: A kick sampled at edge P0 loads the channel's timeout value T. If no further kick arrives, that channel's `local_rst` rises at edge P0+T+1 and not earlier.
- R3: An `ap_vld` strobe records the code on that channel's `ap_code` slice. At a timeout, the most recently recorded code is captured. This happens only if the channel's pending bit is clear, or is being cleared in that same cycle. Otherwise the earlier capture is kept.
- R4: A timeout raises `local_rst` for that channel only. The pulse lasts exactly `RST_LEN` cycles. At the edge where the pulse ends, the countdown reloads, so with no kicks the local resets start every `RST_LEN`+T+1 cycles.
- R5: A timeout sets the channel's bit in `exc_pending` at the same edge that `local_rst` rises. `exc_irq` is high whenever any pending bit is set.
- R6: When `exc_irq` is high, `exc_cause_ch` is the lowest index with a pending bit, and `exc_cause_ap` is the code captured for that channel. Channels that time out in the same cycle all get their pending bits set.
- R7: Pending bits are cleared by writing one: `clr_we` high with the matching `clr_mask` bit set. A bit that is not written stays set. If a timeout and a clear hit the same bit in the same cycle, the timeout wins.
- R8: The `ESC_LIMIT`-th timeout in a row on one channel, with no accepted kick in between, pulses `glb_rst_req` for one cycle at the same edge that its `local_rst` rises. The run count then starts again from zero, and an accepted kick also resets it.
- R9: While a channel's `ch_en` bit is 0, its countdown is frozen, it raises no new timeout, and its kicks are ignored. After the bit is set again, counting continues from the frozen value.
- R10: A configuration write (`cfg_we`, `cfg_sel`, `cfg_timeout`) changes the stored timeout of the selected channel only. It does not disturb a countdown that is already running. The new value takes effect at the next reload.
- R11: A kick that arrives while the channel's `local_rst` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | N_CH | Per-channel enable |
| kick | input | N_CH | Per-channel liveness proof |
| ap_vld | input | N_CH | Per-channel access-point strobe |
| ap_code | input | N_CH*AP_W | Access-point codes, channel i at bits [i*AP_W +: AP_W] |
| cfg_we | input | 1 | Timeout write strobe |
| cfg_sel | input | $clog2(N_CH) | Channel selected for the timeout write |
| cfg_timeout | input | CNT_W | Timeout value in clock cycles |
| clr_we | input | 1 | Pending-bit clear strobe |
| clr_mask | input | N_CH | Write-one-to-clear mask |
| local_rst | output | N_CH | Per-channel local reset |
| exc_pending | output | N_CH | Sticky per-channel exception bits |
| exc_irq | output | 1 | Exception to the monitoring layer above |
| exc_cause_ch | output | $clog2(N_CH) | Lowest pending channel |
| exc_cause_ap | output | AP_W | Access point captured for that channel |
| glb_rst_req | output | 1 | One-cycle global reset request |

## Verification
The bench builds the block with four channels, 8-bit counters, `RST_LEN`=4, `ESC_LIMIT`=3 and `DEF_TIMEOUT`=20. With these values, every channel can be swept over timeouts 0 to 5, and each sweep ends after a few tens of cycles. The full escalation cycle, including its restart, fits in under fifty cycles. Short timeouts also let the bench line up a simultaneous timeout on two channels, and make a clear land on the exact edge of a timeout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        PH_WATCH   = 1'b0,
        PH_RECOVER = 1'b1
    } wd_phase_e;

endpackage

// File: rtl/wdog_chan.sv
module wdog_chan
    import wdog_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int AP_W        = 8,
    parameter int RST_LEN     = 4,
    parameter int ESC_LIMIT   = 3,
    parameter int DEF_TIMEOUT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             kick_i,
    input  logic             ap_vld_i,
    input  logic [AP_W-1:0]  ap_i,
    input  logic             cfg_we_i,
    input  logic [CNT_W-1:0] cfg_val_i,
    output logic             expire_o,
    output logic             escalate_o,
    output logic             lrst_o,
    output logic [AP_W-1:0]  last_ap_o
);

    localparam int RC_W   = $clog2(RST_LEN + 1);
    localparam int MISS_W = $clog2(ESC_LIMIT + 1);

    typedef struct packed {
        wd_phase_e          phase;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   tmo;
        logic [RC_W-1:0]    rcnt;
        logic [MISS_W-1:0]  miss;
        logic [AP_W-1:0]    last_ap;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     expire_d, escalate_d;

    always_comb begin
        s_d        = s_q;
        expire_d   = 1'b0;
        escalate_d = 1'b0;

        if (cfg_we_i) begin
            s_d.tmo = cfg_val_i;
        end
        if (ap_vld_i) begin
            s_d.last_ap = ap_i;
        end

        unique case (s_q.phase)
            PH_RECOVER: begin
                if (s_q.rcnt == RC_W'(1)) begin
                    s_d.rcnt  = '0;
                    s_d.phase = PH_WATCH;
                    s_d.cnt   = s_q.tmo;
                end else begin
                    s_d.rcnt = s_q.rcnt - RC_W'(1);
                end
            end
            default: begin
                if (en_i) begin
                    if (kick_i) begin
                        s_d.cnt  = s_q.tmo;
                        s_d.miss = '0;
                    end else if (s_q.cnt == '0) begin
                        expire_d  = 1'b1;
                        s_d.phase = PH_RECOVER;
                        s_d.rcnt  = RC_W'(RST_LEN);
                        if (s_q.miss == MISS_W'(ESC_LIMIT - 1)) begin
                            escalate_d = 1'b1;
                            s_d.miss   = '0;
                        end else begin
                            s_d.miss = s_q.miss + MISS_W'(1);
                        end
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase   <= PH_WATCH;
            s_q.cnt     <= CNT_W'(DEF_TIMEOUT);
            s_q.tmo     <= CNT_W'(DEF_TIMEOUT);
            s_q.rcnt    <= '0;
            s_q.miss    <= '0;
            s_q.last_ap <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign expire_o   = expire_d;
    assign escalate_o = escalate_d;
    assign lrst_o     = (s_q.phase == PH_RECOVER);
    assign last_ap_o  = s_q.last_ap;

endmodule

// File: rtl/wdog_prio.sv
module wdog_prio #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/wdog_status.sv
module wdog_status #(
    parameter int N_CH = 4,
    parameter int AP_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH-1:0]            expire_i,
    input  logic [N_CH-1:0]            escalate_i,
    input  logic [N_CH-1:0][AP_W-1:0]  last_ap_i,
    input  logic                       clr_we_i,
    input  logic [N_CH-1:0]            clr_mask_i,
    output logic [N_CH-1:0]            pend_o,
    output logic [N_CH-1:0][AP_W-1:0]  cap_o,
    output logic                       glb_o
);

    typedef struct packed {
        logic [N_CH-1:0]           pend;
        logic [N_CH-1:0][AP_W-1:0] cap;
        logic                      glb;
    } stat_st_t;

    stat_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.glb = |escalate_i;
        for (int i = 0; i < N_CH; i++) begin
            if (clr_we_i && clr_mask_i[i]) begin
                s_d.pend[i] = 1'b0;
            end
            if (expire_i[i]) begin
                if (!s_q.pend[i] || (clr_we_i && clr_mask_i[i])) begin
                    s_d.cap[i] = last_ap_i[i];
                end
                s_d.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
    assign cap_o  = s_q.cap;
    assign glb_o  = s_q.glb;

endmodule

// File: rtl/multi_wdog.sv
module multi_wdog #(
    parameter int N_CH        = 4,
    parameter int CNT_W       = 16,
    parameter int AP_W        = 8,
    parameter int RST_LEN     = 4,
    parameter int ESC_LIMIT   = 3,
    parameter int DEF_TIMEOUT = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CH-1:0]           ch_en,
    input  logic [N_CH-1:0]           kick,
    input  logic [N_CH-1:0]           ap_vld,
    input  logic [N_CH*AP_W-1:0]      ap_code,
    input  logic                      cfg_we,
    input  logic [$clog2(N_CH)-1:0]   cfg_sel,
    input  logic [CNT_W-1:0]          cfg_timeout,
    input  logic                      clr_we,
    input  logic [N_CH-1:0]           clr_mask,
    output logic [N_CH-1:0]           local_rst,
    output logic [N_CH-1:0]           exc_pending,
    output logic                      exc_irq,
    output logic [$clog2(N_CH)-1:0]   exc_cause_ch,
    output logic [AP_W-1:0]           exc_cause_ap,
    output logic                      glb_rst_req
);

    localparam int SEL_W = $clog2(N_CH);

    logic [N_CH-1:0]           expire;
    logic [N_CH-1:0]           escalate;
    logic [N_CH-1:0][AP_W-1:0] last_ap;
    logic [N_CH-1:0][AP_W-1:0] cap_ap;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        wdog_chan #(
            .CNT_W       (CNT_W),
            .AP_W        (AP_W),
            .RST_LEN     (RST_LEN),
            .ESC_LIMIT   (ESC_LIMIT),
            .DEF_TIMEOUT (DEF_TIMEOUT)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (ch_en[g]),
            .kick_i     (kick[g]),
            .ap_vld_i   (ap_vld[g]),
            .ap_i       (ap_code[g*AP_W +: AP_W]),
            .cfg_we_i   (cfg_we && (cfg_sel == SEL_W'(g))),
            .cfg_val_i  (cfg_timeout),
            .expire_o   (expire[g]),
            .escalate_o (escalate[g]),
            .lrst_o     (local_rst[g]),
            .last_ap_o  (last_ap[g])
        );
    end

    wdog_status #(
        .N_CH (N_CH),
        .AP_W (AP_W)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .escalate_i (escalate),
        .last_ap_i  (last_ap),
        .clr_we_i   (clr_we),
        .clr_mask_i (clr_mask),
        .pend_o     (exc_pending),
        .cap_o      (cap_ap),
        .glb_o      (glb_rst_req)
    );

    wdog_prio #(
        .N     (N_CH),
        .IDX_W (SEL_W)
    ) u_prio (
        .req_i (exc_pending),
        .idx_o (exc_cause_ch)
    );

    assign exc_irq      = |exc_pending;
    assign exc_cause_ap = cap_ap[exc_cause_ch];

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int N_CH    = 4,
    parameter int RST_LEN = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_CH-1:0]         ch_en,
    input logic                    clr_we,
    input logic [N_CH-1:0]         clr_mask,
    input logic [N_CH-1:0]         local_rst,
    input logic [N_CH-1:0]         exc_pending,
    input logic                    exc_irq,
    input logic [$clog2(N_CH)-1:0] exc_cause_ch,
    input logic                    glb_rst_req
);

    localparam int LW = $clog2(RST_LEN + 2);

    logic [N_CH-1:0][LW-1:0] hi_len;
    logic [N_CH-1:0]         low_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (!local_rst[i]) begin
                    hi_len[i] <= '0;
                end else if (hi_len[i] != '1) begin
                    hi_len[i] <= hi_len[i] + LW'(1);
                end
            end
        end
    end

    always_comb begin
        low_mask = (N_CH'(1) << exc_cause_ch) - N_CH'(1);
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_prop
        AST_PEND_WITH_LRST: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(exc_pending[g]) |-> $rose(local_rst[g])); // R5
        AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[g] && !local_rst[g]) |=> !local_rst[g]); // R9
        AST_LRST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(local_rst[g]) |-> (hi_len[g] == LW'(RST_LEN))); // R4
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (exc_pending[g] && !(clr_we && clr_mask[g])) |=> exc_pending[g]); // R7
    end

    AST_CAUSE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        exc_irq |-> (exc_pending[exc_cause_ch] && ((exc_pending & low_mask) == '0))); // R6
    AST_GLB_WITH_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        glb_rst_req |-> ((local_rst & ~$past(local_rst)) != '0)); // R8

endmodule

bind multi_wdog wdog_chk #(
    .N_CH    (N_CH),
    .RST_LEN (RST_LEN)
) i_wdog_chk (.*);

// File: tb/test_multi_wdog.sv
module test_multi_wdog;

    localparam int N_CH = 4;
    localparam int CNT_W = 8;
    localparam int AP_W = 8;
    localparam int RST_LEN = 4;
    localparam int ESC_LIMIT = 3;
    localparam int DEF_TIMEOUT = 20;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [N_CH-1:0]       ch_en = '0;
    logic [N_CH-1:0]       kick = '0;
    logic [N_CH-1:0]       ap_vld = '0;
    logic [N_CH*AP_W-1:0]  ap_code = '0;
    logic                  cfg_we = 1'b0;
    logic [1:0]            cfg_sel = '0;
    logic [CNT_W-1:0]      cfg_timeout = '0;
    logic                  clr_we = 1'b0;
    logic [N_CH-1:0]       clr_mask = '0;
    logic [N_CH-1:0]       local_rst;
    logic [N_CH-1:0]       exc_pending;
    logic                  exc_irq;
    logic [1:0]            exc_cause_ch;
    logic [AP_W-1:0]       exc_cause_ap;
    logic                  glb_rst_req;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    multi_wdog #(
        .N_CH(N_CH), .CNT_W(CNT_W), .AP_W(AP_W), .RST_LEN(RST_LEN),
        .ESC_LIMIT(ESC_LIMIT), .DEF_TIMEOUT(DEF_TIMEOUT)
    ) i_multi_wdog (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .kick(kick), .ap_vld(ap_vld),
        .ap_code(ap_code), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_timeout(cfg_timeout), .clr_we(clr_we), .clr_mask(clr_mask),
        .local_rst(local_rst), .exc_pending(exc_pending), .exc_irq(exc_irq),
        .exc_cause_ch(exc_cause_ch), .exc_cause_ap(exc_cause_ap),
        .glb_rst_req(glb_rst_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        ch_en = '0; kick = '0; ap_vld = '0; ap_code = '0;
        cfg_we = 1'b0; clr_we = 1'b0; clr_mask = '0;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic set_tmo(input int ch, input int t);
        cfg_we = 1'b1; cfg_sel = 2'(ch); cfg_timeout = CNT_W'(t);
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic kick_once(input logic [N_CH-1:0] m);
        kick = m;
        tick(1);
        kick = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state and default timeout
        do_reset();
        check("R1", "local_rst", 32'(local_rst), 0);
        check("R1", "exc_pending", 32'(exc_pending), 0);
        check("R1", "exc_irq", 32'(exc_irq), 0);
        check("R1", "glb_rst_req", 32'(glb_rst_req), 0);
        ch_en = 4'b0001;
        tick(DEF_TIMEOUT);
        check("R1", "no early timeout", 32'(local_rst), 0);
        tick(1);
        check("R1", "default timeout", 32'(local_rst), 1);

        // R2, R4, R10: sweep channels and timeouts
        for (int ch = 0; ch < N_CH; ch++) begin
            for (int t = 0; t < 6; t++) begin
                do_reset();
                set_tmo(ch, t);
                ch_en = 4'(1 << ch);
                kick_once(4'(1 << ch));
                tick(t);
                check("R2", "before expiry", 32'(local_rst), 0);
                tick(1);
                check("R2", "at expiry", 32'(local_rst), 32'(1 << ch));
                check("R4", "only failing channel", 32'(exc_pending), 32'(1 << ch));
            end
        end

        // R4, R8: period and escalation
        do_reset();
        set_tmo(0, 3);
        ch_en = 4'b0001;
        kick_once(4'b0001);
        tick(4);
        check("R4", "first reset", 32'(local_rst), 1);
        tick(7);
        check("R4", "reset ended", 32'(local_rst), 0);
        tick(1);
        check("R4", "second reset", 32'(local_rst), 1);
        check("R8", "no escalation yet", 32'(glb_rst_req), 0);
        tick(8);
        check("R8", "third timeout escalates", 32'(glb_rst_req), 1);
        tick(1);
        check("R8", "single cycle", 32'(glb_rst_req), 0);
        tick(7);
        check("R8", "run restarted", 32'(glb_rst_req), 0);
        check("R4", "fourth reset", 32'(local_rst), 1);
        tick(16);
        check("R8", "sixth timeout escalates", 32'(glb_rst_req), 1);

        // R11, R8: kick during local reset ignored, kick in window clears run
        do_reset();
        set_tmo(1, 3);
        ch_en = 4'b0010;
        kick_once(4'b0010);
        tick(4);
        kick_once(4'b0010);
        tick(6);
        check("R11", "kick in reset ignored low", 32'(local_rst), 0);
        tick(1);
        check("R11", "kick in reset ignored high", 32'(local_rst), 32'h2);
        tick(4);
        kick_once(4'b0010);
        tick(3);
        check("R2", "kick reloads", 32'(local_rst), 0);
        tick(1);
        check("R8", "kick broke run", 32'(glb_rst_req), 0);
        check("R2", "timeout after kick", 32'(local_rst), 32'h2);

        // R3, R5, R6, R7: capture, cause, clear
        do_reset();
        set_tmo(1, 3);
        set_tmo(2, 3);
        ap_vld = 4'b0110;
        ap_code[8 +: 8] = 8'h5A; ap_code[16 +: 8] = 8'h77;
        tick(1);
        ap_vld = 4'b0010;
        ap_code[8 +: 8] = 8'h3C;
        tick(1);
        ap_vld = '0;
        ch_en = 4'b0110;
        kick_once(4'b0110);
        tick(3);
        check("R5", "irq idle", 32'(exc_irq), 0);
        tick(1);
        check("R6", "both logged", 32'(exc_pending), 32'h6);
        check("R5", "irq raised", 32'(exc_irq), 1);
        check("R6", "lowest cause", 32'(exc_cause_ch), 1);
        check("R3", "latest code", 32'(exc_cause_ap), 32'h3C);
        clr_we = 1'b1; clr_mask = 4'b0010; ch_en = 4'b0100;
        tick(1);
        clr_we = 1'b0; clr_mask = '0;
        check("R7", "cleared one", 32'(exc_pending), 32'h4);
        check("R6", "next cause", 32'(exc_cause_ch), 2);
        check("R6", "next code", 32'(exc_cause_ap), 32'h77);
        ap_vld = 4'b0100; ap_code[16 +: 8] = 8'hEE;
        tick(1);
        ap_vld = '0;
        tick(6);
        check("R3", "first capture kept", 32'(exc_cause_ap), 32'h77);
        check("R7", "sticky", 32'(exc_pending), 32'h4);
        tick(7);
        clr_we = 1'b1; clr_mask = 4'b0100;
        tick(1);
        clr_we = 1'b0; clr_mask = '0;
        check("R7", "set beats clear", 32'(exc_pending), 32'h4);
        check("R3", "recaptured", 32'(exc_cause_ap), 32'hEE);
        clr_we = 1'b1; clr_mask = 4'b0100;
        tick(1);
        clr_we = 1'b0; clr_mask = '0;
        check("R7", "all clear", 32'(exc_pending), 0);
        check("R5", "irq dropped", 32'(exc_irq), 0);

        // R9: disabled channel frozen, kicks ignored
        do_reset();
        set_tmo(3, 5);
        ch_en = 4'b1000;
        kick_once(4'b1000);
        tick(2);
        ch_en = '0;
        for (int k = 0; k < 10; k++) begin
            kick_once(4'b1000);
            tick(1);
        end
        check("R9", "no timeout while off", 32'(local_rst), 0);
        check("R9", "no exception while off", 32'(exc_pending), 0);
        ch_en = 4'b1000;
        tick(3);
        check("R9", "frozen count low", 32'(local_rst), 0);
        tick(1);
        check("R9", "frozen count expiry", 32'(local_rst), 32'h8);

        // R10: config takes effect at next reload
        do_reset();
        set_tmo(0, 5);
        ch_en = 4'b0001;
        kick_once(4'b0001);
        tick(1);
        set_tmo(0, 1);
        tick(3);
        check("R10", "running count kept", 32'(local_rst), 0);
        tick(1);
        check("R10", "old timeout expiry", 32'(local_rst), 1);
        tick(5);
        check("R10", "new value low", 32'(local_rst), 0);
        tick(1);
        check("R10", "new value expiry", 32'(local_rst), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule